// File: doc/BRIEF.md
# Narrow-Access Register Bridge

This block lets a host issue byte, halfword and word reads and writes to a peripheral register file that only accepts whole aligned 32-bit transfers. Every downstream transfer goes to the host address with its two low bits cleared. A narrow read fetches the word and returns the selected lane, shifted down and zero-extended. A narrow write fetches the word, replaces the selected lane and writes the merged word back.

Two registers that share one word get special handling. A halfword write to the transfer-mode half (offset 0x0C) issues no write. It reads the word, merges the new half and keeps the result in an internal shadow. A halfword write to the command half (offset 0x0E) does not read the peripheral. It merges the new command into the shadow and issues one write that carries both halves. Reads of the capability word at offset 0x40 always return bit 24 (3.3 V support) as 1.

The peripheral runs on a slow clock and can lose writes that arrive close together. After each downstream write the host port therefore stays not-ready for a fixed gap, given in system clock cycles and derived from the clock frequency and a gap in microseconds. The host side uses a valid/ready request with one outstanding transfer and a one-cycle response pulse.

Top module: `narrow_reg_bridge`

## Requirements
- R1: Every downstream request carries a byte address whose two low bits are 0, equal to the host address with those bits cleared.
- R2: A byte read (size 2'b00) returns bits 8*a[1:0]+7 down to 8*a[1:0] of the fetched word in host_rdata[7:0], with bits 31:8 zero.
- R3: A halfword read (size 2'b01) returns word bits 31:16 when a[1]=1 and bits 15:0 when a[1]=0, in host_rdata[15:0], with the upper half zero.
- R4: A byte write, or a halfword write to any address other than 0x0C or 0x0E, performs exactly one downstream read, then exactly one write. That write equals the fetched word with only the addressed lane replaced.
- R5: A halfword write to 0x0C performs one downstream read and no downstream write. The peripheral word is left unchanged, and the shadow becomes the fetched word with bits 15:0 replaced.
- R6: A halfword write to 0x0E performs no downstream read and one write to 0x0C. Bits 31:16 of that write are the new value and bits 15:0 come from the shadow.
- R7: After a downstream write is acknowledged, host_ready stays low and no new downstream request starts for GAP cycles, where GAP = (CLK_HZ/1e6)*GAP_US.
- R8: Any read of the word at 0x40 sees bit 24 of that word as 1, whatever the peripheral returns.
- R9: After reset host_ready is 1, pr_req and host_rsp_valid are 0, and the shadow is zero.
- R10: A word write (size 2'b10, or the reserved code 2'b11) issues one downstream write of host_wdata with no downstream read.
- R11: Each accepted request produces exactly one host_rsp_valid pulse, and host_rdata is 0 for writes. A read causes no downstream write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Bridge can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Write value, right-aligned for narrow sizes |
| host_rsp_valid | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, zero for writes |
| pr_req | output | 1 | Downstream request, held until acknowledged |
| pr_write | output | 1 | Downstream direction |
| pr_addr | output | ADDR_W | Downstream word-aligned byte address |
| pr_wdata | output | 32 | Downstream write word |
| pr_ack | input | 1 | Downstream acknowledge, with read data |
| pr_rdata | input | 32 | Downstream read word |

## Verification
The assertions assume the peripheral acknowledges each request within bounded time. They also assume pr_rdata is valid in the acknowledge cycle, and that the host holds its request fields steady while host_valid waits for host_ready. The bench peripheral model acknowledges every request one cycle after it appears, and the driver changes the request fields only on falling edges. Halfword addresses used in the stimulus are always even, so the lane choice never depends on address bit 0.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int NRB_DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } nrb_size_e;

  typedef enum logic [2:0] {
    K_READ    = 3'd0,
    K_WORD_WR = 3'd1,
    K_RMW     = 3'd2,
    K_TM      = 3'd3,
    K_CMD     = 3'd4
  } nrb_kind_e;

  // Mask of the bits a transfer of this size touches.
  function automatic logic [NRB_DW-1:0] nrb_lane_mask(logic [1:0] size, logic [1:0] lane);
    case (size)
      SZ_BYTE: return 32'h0000_00FF << {lane, 3'b000};
      SZ_HALF: return lane[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      default: return '1;
    endcase
  endfunction

  // Selected lane moved down to bit 0 and zero-extended.
  function automatic logic [NRB_DW-1:0] nrb_lane_get(logic [1:0] size, logic [1:0] lane,
                                                      logic [NRB_DW-1:0] word);
    logic [NRB_DW-1:0] sh;
    sh = word >> {lane, 3'b000};
    case (size)
      SZ_BYTE: return {24'd0, sh[7:0]};
      SZ_HALF: return lane[1] ? {16'd0, word[31:16]} : {16'd0, word[15:0]};
      default: return word;
    endcase
  endfunction

  // Replicate the narrow value over every lane, then keep only the masked lane.
  function automatic logic [NRB_DW-1:0] nrb_lane_put(logic [1:0] size, logic [1:0] lane,
                                                      logic [NRB_DW-1:0] old_w,
                                                      logic [NRB_DW-1:0] val);
    logic [NRB_DW-1:0] m;
    logic [NRB_DW-1:0] rep;
    m = nrb_lane_mask(size, lane);
    case (size)
      SZ_BYTE: rep = {4{val[7:0]}};
      SZ_HALF: rep = {2{val[15:0]}};
      default: rep = val;
    endcase
    return (old_w & ~m) | (rep & m);
  endfunction
endpackage

// File: rtl/nrb_lane_unit.sv
module nrb_lane_unit
  import nrb_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lane,
  input  logic [NRB_DW-1:0] old_word,
  input  logic [NRB_DW-1:0] new_val,
  output logic [NRB_DW-1:0] rd_lane,
  output logic [NRB_DW-1:0] merged
);
  always_comb begin
    rd_lane = nrb_lane_get(size, lane, old_word);
    merged  = nrb_lane_put(size, lane, old_word, new_val);
  end
endmodule

// File: rtl/nrb_gap_timer.sv
module nrb_gap_timer #(
  parameter int GAP = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (start)      count <= CW'(GAP);
    else if (count != 0) count <= count - 1'b1;
  end

  assign busy = (count != 0);

  p_gap_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (count == $past(count) - 1'b1));

  p_gap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/nrb_shadow.sv
module nrb_shadow
  import nrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NRB_DW-1:0] din,
  output logic [NRB_DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge
  import nrb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_HZ  = 2_000_000,
  parameter int GAP_US  = 6,
  parameter int TM_OFF  = 'h0C,
  parameter int CMD_OFF = 'h0E,
  parameter int CAP_OFF = 'h40,
  parameter int CAP_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [1:0]        host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              host_rsp_valid,
  output logic [31:0]       host_rdata,
  output logic              pr_req,
  output logic              pr_write,
  output logic [ADDR_W-1:0] pr_addr,
  output logic [31:0]       pr_wdata,
  input  logic              pr_ack,
  input  logic [31:0]       pr_rdata
);
  localparam int GAP_RAW = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam logic [ADDR_W-1:0] TM_A  = ADDR_W'(TM_OFF);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFF);
  localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_OFF);
  localparam logic [31:0] CAP_MASK = 32'(1) << CAP_BIT;

  typedef enum logic [2:0] {S_IDLE, S_MRG, S_RD, S_WR, S_RSP} state_e;

  state_e            state;
  nrb_kind_e         req_kind;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic [31:0]       wr_word;
  logic [31:0]       rsp_data;

  // Named internal events.
  logic        accept;
  logic        gap_start;
  logic        gap_busy;
  logic        shadow_load;
  logic [31:0] shadow_q;
  logic        cap_hit;
  logic [31:0] rd_forced;
  logic [31:0] merge_old;
  logic [31:0] lane_rd;
  logic [31:0] lane_merged;
  nrb_kind_e   in_kind;

  assign accept      = host_valid && host_ready;
  assign gap_start   = (state == S_WR) && pr_ack;
  assign shadow_load = (state == S_RD) && pr_ack && (req_kind == K_TM);
  assign cap_hit     = (req_addr[ADDR_W-1:2] == CAP_A[ADDR_W-1:2]);
  assign rd_forced   = cap_hit ? (pr_rdata | CAP_MASK) : pr_rdata;
  assign merge_old   = (req_kind == K_CMD) ? shadow_q : rd_forced;

  always_comb begin
    if (!host_write)                                   in_kind = K_READ;
    else if (host_size[1])                             in_kind = K_WORD_WR;
    else if (host_size == SZ_HALF && host_addr == TM_A)  in_kind = K_TM;
    else if (host_size == SZ_HALF && host_addr == CMD_A) in_kind = K_CMD;
    else                                               in_kind = K_RMW;
  end

  nrb_lane_unit u_lane (
    .size     (req_size),
    .lane     (req_addr[1:0]),
    .old_word (merge_old),
    .new_val  (req_wdata),
    .rd_lane  (lane_rd),
    .merged   (lane_merged)
  );

  nrb_shadow u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (shadow_load),
    .din   (lane_merged),
    .q     (shadow_q)
  );

  nrb_gap_timer #(.GAP(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gap_start),
    .busy  (gap_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_kind  <= K_READ;
      req_size  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      wr_word   <= '0;
      rsp_data  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          req_kind  <= in_kind;
          req_size  <= host_size;
          req_addr  <= host_addr;
          req_wdata <= host_wdata;
          case (in_kind)
            K_WORD_WR: begin wr_word <= host_wdata; state <= S_WR; end
            K_CMD:     state <= S_MRG;
            default:   state <= S_RD;
          endcase
        end
        S_MRG: begin
          wr_word <= lane_merged;
          state   <= S_WR;
        end
        S_RD: if (pr_ack) begin
          case (req_kind)
            K_READ:  begin rsp_data <= lane_rd; state <= S_RSP; end
            K_RMW:   begin wr_word <= lane_merged; state <= S_WR; end
            default: begin rsp_data <= '0; state <= S_RSP; end
          endcase
        end
        S_WR: if (pr_ack) begin
          rsp_data <= '0;
          state    <= S_RSP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_ready     = (state == S_IDLE) && !gap_busy;
  assign host_rsp_valid = (state == S_RSP);
  assign host_rdata     = rsp_data;
  assign pr_req         = (state == S_RD) || (state == S_WR);
  assign pr_write       = (state == S_WR);
  assign pr_addr        = {req_addr[ADDR_W-1:2], 2'b00};
  assign pr_wdata       = wr_word;

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pr_req |-> (pr_addr[1:0] == 2'b00));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_req && !pr_ack) |=> (pr_req && $stable(pr_addr) && $stable(pr_write)));

  p_tm_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_req && pr_write) |-> (req_kind != K_TM));

  p_cmd_noread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_req && !pr_write) |-> (req_kind != K_CMD));

  p_read_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_req && pr_write) |-> (req_kind != K_READ));

  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pr_req) |-> !gap_busy);

  p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> !host_rsp_valid);

  p_cap_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && req_kind == K_READ && req_size[1] && cap_hit) |-> host_rdata[CAP_BIT]);
endmodule

// File: tb/narrow_reg_bridge_tb.sv
module narrow_reg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 12;  // 2 MHz clock, 6 us gap

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [1:0] host_size = 2'd0;
  logic [7:0] host_addr = 8'd0;
  logic [31:0] host_wdata = 32'd0;
  logic host_ready, host_rsp_valid, pr_req, pr_write;
  logic [31:0] host_rdata, pr_wdata;
  logic [7:0] pr_addr;
  logic pr_ack = 1'b0;
  logic [31:0] pr_rdata = 32'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  narrow_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_size(host_size), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rsp_valid(host_rsp_valid), .host_rdata(host_rdata),
    .pr_req(pr_req), .pr_write(pr_write), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
    .pr_ack(pr_ack), .pr_rdata(pr_rdata)
  );

  int chk = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] dmem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] ref_shadow = 32'd0;
  logic [31:0] exp_rsp_q[$];
  string       exp_tag_q[$];
  logic [39:0] exp_wr_q[$];
  int rsp_cnt = 0, rd_cnt = 0, wr_cnt = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    chk++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Peripheral model: acknowledges one cycle after a request appears.
  always @(posedge clk) begin
    if (!rst_n) pr_ack <= 1'b0;
    else if (pr_req && !pr_ack) begin
      pr_ack <= 1'b1;
      if (pr_write) dmem[pr_addr[7:2]] <= pr_wdata;
      else          pr_rdata <= dmem[pr_addr[7:2]];
    end else pr_ack <= 1'b0;
  end

  // Monitor / scoreboard.
  int  ncyc = 0, last_wr = 0;
  bit  have_wr = 1'b0, prev_req = 1'b0, ready_in_gap = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (host_rsp_valid) begin
        rsp_cnt++;
        if (exp_rsp_q.size() == 0) check(1'b0, "R11 unexpected response", host_rdata, 32'd0);
        else begin
          automatic logic [31:0] e = exp_rsp_q.pop_front();
          automatic string t = exp_tag_q.pop_front();
          check(host_rdata === e, t, host_rdata, e);
        end
      end
      if (pr_req && pr_write && pr_ack) begin
        wr_cnt++;
        if (exp_wr_q.size() == 0) check(1'b0, "R5 unexpected downstream write", pr_wdata, 32'd0);
        else begin
          automatic logic [39:0] w = exp_wr_q.pop_front();
          check(pr_addr == w[39:32] && pr_wdata === w[31:0], "R4 downstream write word",
                {pr_addr, pr_wdata[23:0]}, {w[39:32], w[23:0]});
        end
        have_wr = 1'b1; last_wr = ncyc; ready_in_gap = 1'b0;
      end else if (have_wr && ncyc > last_wr && ncyc <= last_wr + GAP) begin
        if (host_ready) ready_in_gap = 1'b1;
        if (ncyc == last_wr + GAP)
          check(!ready_in_gap, "R7 host_ready low during gap", 32'(ready_in_gap), 32'd0);
      end
      if (pr_req && !pr_write && pr_ack) rd_cnt++;
      if (pr_req && !prev_req) begin
        check(pr_addr[1:0] == 2'b00, "R1 aligned downstream address", 32'(pr_addr), 32'(pr_addr & 8'hFC));
        if (have_wr)
          check(ncyc - last_wr >= GAP + 2, "R7 request start after gap", 32'(ncyc - last_wr), 32'(GAP + 2));
      end
      prev_req = pr_req;
    end
  end

  function automatic logic [31:0] ref_rd(int idx);
    return ref_mem[idx] | ((idx == 16) ? 32'h0100_0000 : 32'd0);
  endfunction

  function automatic logic [31:0] pick(logic [1:0] sz, logic [7:0] a, logic [31:0] w);
    if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
    if (sz == 2'd1) return a[1] ? (w >> 16) : (w & 32'hFFFF);
    return w;
  endfunction

  function automatic logic [31:0] put(logic [1:0] sz, logic [7:0] a, logic [31:0] o, logic [31:0] d);
    int sh;
    if (sz == 2'd0) begin sh = 8 * a[1:0];  return (o & ~(32'hFF << sh)) | ((d & 32'hFF) << sh); end
    if (sz == 2'd1) begin sh = 16 * a[1];   return (o & ~(32'hFFFF << sh)) | ((d & 32'hFFFF) << sh); end
    return d;
  endfunction

  task automatic xfer(bit wr, logic [1:0] sz, logic [7:0] a, logic [31:0] d, string tag);
    int idx = a[7:2];
    int exp_reads = 0;
    int r0, w0, c0;
    logic [31:0] nw;
    if (!wr) begin
      exp_rsp_q.push_back(pick(sz, a, ref_rd(idx))); exp_reads = 1;
    end else begin
      exp_rsp_q.push_back(32'd0);
      if (sz[1]) begin
        exp_wr_q.push_back({a & 8'hFC, d}); ref_mem[idx] = d;
      end else if (sz == 2'd1 && a == 8'h0C) begin
        ref_shadow = put(sz, a, ref_rd(idx), d); exp_reads = 1;
      end else if (sz == 2'd1 && a == 8'h0E) begin
        nw = {d[15:0], ref_shadow[15:0]};
        exp_wr_q.push_back({8'h0C, nw}); ref_mem[idx] = nw;
      end else begin
        nw = put(sz, a, ref_rd(idx), d);
        exp_wr_q.push_back({a & 8'hFC, nw}); ref_mem[idx] = nw; exp_reads = 1;
      end
    end
    exp_tag_q.push_back(tag);
    r0 = rd_cnt; w0 = wr_cnt; c0 = rsp_cnt;
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_size = sz; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_wdata = 32'hDEAD_BEEF;
    while (rsp_cnt == c0) @(negedge clk);
    check(rd_cnt - r0 == exp_reads, {tag, " downstream read count"}, 32'(rd_cnt - r0), 32'(exp_reads));
    check(exp_wr_q.size() == 0, {tag, " downstream write issued"}, 32'(exp_wr_q.size()), 32'd0);
    if (!wr) check(wr_cnt == w0, {tag, " no write on read (R11)"}, 32'(wr_cnt - w0), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      chk++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", chk, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dmem[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0101_0111);
      ref_mem[i] = dmem[i];
    end
    dmem[16] = 32'h0000_00F0; ref_mem[16] = 32'h0000_00F0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready == 1'b1, "R9 ready after reset", 32'(host_ready), 32'd1);
    check(pr_req == 1'b0, "R9 no request after reset", 32'(pr_req), 32'd0);
    check(host_rsp_valid == 1'b0, "R9 no response after reset", 32'(host_rsp_valid), 32'd0);
    // R9/R6: shadow starts at zero, command write merges it without a read
    xfer(1'b1, 2'd1, 8'h0E, 32'h0000_ABCD, "R9 R6 command write after reset");
    xfer(1'b0, 2'd2, 8'h0C, 32'd0, "R6 word read of command word");
    xfer(1'b0, 2'd2, 8'h14, 32'd0, "R1 word read");
    for (int k = 0; k < 4; k++)
      xfer(1'b0, 2'd0, 8'h24 + 8'(k), 32'hFFFF_FFFF, "R2 byte read lane");
    xfer(1'b0, 2'd1, 8'h30, 32'd0, "R3 half read low");
    xfer(1'b0, 2'd1, 8'h32, 32'd0, "R3 half read high");
    xfer(1'b0, 2'd2, 8'h40, 32'd0, "R8 capability word read");
    xfer(1'b0, 2'd0, 8'h43, 32'd0, "R8 capability byte read");
    xfer(1'b0, 2'd1, 8'h42, 32'd0, "R8 capability half read");
    xfer(1'b1, 2'd0, 8'h21, 32'h0000_005A, "R4 byte write lane 1");
    xfer(1'b0, 2'd2, 8'h20, 32'd0, "R4 readback after byte write");
    xfer(1'b1, 2'd1, 8'h3A, 32'h0000_C0DE, "R4 half write high");
    xfer(1'b0, 2'd2, 8'h38, 32'd0, "R4 readback after half write");
    xfer(1'b1, 2'd2, 8'h28, 32'h1357_9BDF, "R10 word write");
    xfer(1'b1, 2'd3, 8'h2C, 32'h2468_ACE0, "R10 reserved size as word");
    xfer(1'b0, 2'd2, 8'h28, 32'd0, "R10 readback");
    xfer(1'b1, 2'd1, 8'h0C, 32'h0000_1234, "R5 transfer-mode write");
    xfer(1'b0, 2'd2, 8'h0C, 32'd0, "R5 peripheral word unchanged");
    xfer(1'b1, 2'd1, 8'h0E, 32'h0000_5678, "R6 command write carries shadow");
    xfer(1'b0, 2'd2, 8'h0C, 32'd0, "R6 readback of combined word");
    xfer(1'b1, 2'd0, 8'h04, 32'h0000_0011, "R7 back-to-back write A");
    xfer(1'b1, 2'd0, 8'h07, 32'h0000_0022, "R7 back-to-back write B");
    xfer(1'b0, 2'd2, 8'h04, 32'd0, "R7 readback");
    repeat (GAP + 4) @(negedge clk);
    check(exp_rsp_q.size() == 0, "R11 all responses seen", 32'(exp_rsp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", chk, fails);
    $finish;
  end
endmodule